// File: doc/BRIEF.md
# Single-Cycle Register Arithmetic Core

This block is a small processor core that runs one register-to-register instruction in every clock cycle. A program counter addresses an on-chip instruction store. The fetched 16-bit word is split into an operation code, a destination register and two source registers. The sources are read from a sixteen-entry, 8-bit register file, combined by a small arithmetic and logic unit, and written back on the same rising edge that advances the program counter.

The instruction store has its own write port. A host can therefore load a program while the core is held in reset, or patch words while the core runs. A combinational debug port lets the host read any register, and the current program counter is also driven out. Data memory, loads, stores and branches are not part of this block.

Top module: `tiny_rcore`

## Requirements
- R1: While `rst_n` is low, the program counter is 0 and all sixteen registers read 0.
- R2: On every rising edge with `rst_n` high, the program counter increases by one. After 127 it wraps to 0.
- R3: Instruction fields are: bits [15:12] operation code, bits [11:8] destination register, bits [7:4] source A, bits [3:0] source B. The instruction at the current program counter writes its result to the destination on the next rising edge.
- R4: Operation code 0000 writes A + B, keeping only the low 8 bits.
- R5: Operation code 0001 writes A - B, keeping only the low 8 bits.
- R6: Operation code 0010 writes A AND B. Operation code 0011 writes A OR B.
- R7: Operation code 0100 writes the bitwise inverse of A. The source B field has no effect.
- R8: Operation codes 0101 through 1111 leave every register unchanged.
- R9: When `prog_we` is high at a rising edge, `prog_data` is stored at `prog_addr`. The store takes effect whether or not the core is in reset. The new word is fetched from the next cycle onward.
- R10: If the write address equals the program counter in the same cycle, that cycle executes the old word.
- R11: `dbg_val` combinationally shows the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | PC_W (7) | Instruction store write address |
| prog_data | input | 16 | Instruction word to store |
| dbg_sel | input | 4 | Register index for the debug read |
| dbg_val | output | DATA_W (8) | Value of the selected register |
| pc_o | output | PC_W (7) | Current program counter |

## Verification
The bench builds the core with its default values: an 8-bit data path and a 7-bit program counter over 128 instruction words. With these values the counter wraps twice within about three hundred cycles. Small operands are enough to reach 8-bit carry and borrow wrap, for example 0xFF + 0x01 and 0x01 - 0xFF. While the core runs, the bench patches one word at the address currently being fetched and one word further ahead. It then observes the old word executing in the first case and the new words executing on later passes.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int INSN_W  = 16;
  localparam int FIELD_W = 4;
  localparam int NREGS   = 2 ** FIELD_W;

  typedef enum logic [FIELD_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_NOT = 4'd4
  } alu_op_e;

  typedef struct packed {
    logic [FIELD_W-1:0] opc;
    logic [FIELD_W-1:0] dst;
    logic [FIELD_W-1:0] src_a;
    logic [FIELD_W-1:0] src_b;
  } insn_t;
endpackage

// File: rtl/rcore_pc.sv
module rcore_pc #(
  parameter int PC_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  always_comb begin
    pc_en = 1'b1;
    pc_d  = pc_q + {{(PC_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R2: one step per edge, wrapping naturally
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pc_q == PC_W'($past(pc_q) + 1));
endmodule

// File: rtl/rcore_imem.sv
module rcore_imem #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // R9: a stored word is present after the edge
  assert_store_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra,
  input  logic [IDX_W-1:0]  rb,
  input  logic [IDX_W-1:0]  rdbg,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb,
  output logic [DATA_W-1:0] qdbg
);
  localparam int N = 2 ** IDX_W;

  logic [N-1:0][DATA_W-1:0] regs_q;
  logic [N-1:0][DATA_W-1:0] regs_d;

  always_comb begin
    regs_d = regs_q;
    if (we) regs_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign qa   = regs_q[ra];
  assign qb   = regs_q[rb];
  assign qdbg = regs_q[rdbg];

  // R3: the write lands in the addressed register
  assert_wb_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata));

  // R8: no enable, no change anywhere
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q));
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [FIELD_W-1:0] op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  res,
  output logic               res_ok
);
  always_comb begin
    res    = '0;
    res_ok = 1'b1;
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NOT:  res = ~a;
      default: res_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/tiny_rcore.sv
module tiny_rcore
  import rcore_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_we,
  input  logic [PC_W-1:0]      prog_addr,
  input  logic [INSN_W-1:0]    prog_data,
  input  logic [FIELD_W-1:0]   dbg_sel,
  output logic [DATA_W-1:0]    dbg_val,
  output logic [PC_W-1:0]      pc_o
);
  logic [PC_W-1:0]   pc;
  logic [INSN_W-1:0] fetch_word;
  insn_t             insn;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_res;
  logic              alu_ok;

  rcore_pc #(.PC_W(PC_W)) u_pc (
    .clk (clk),
    .rst_n (rst_n),
    .pc  (pc)
  );

  rcore_imem #(.ADDR_W(PC_W), .WORD_W(INSN_W)) u_imem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prog_we),
    .wr_addr (prog_addr),
    .wr_data (prog_data),
    .rd_addr (pc),
    .rd_data (fetch_word)
  );

  assign insn = insn_t'(fetch_word);

  rcore_regfile #(.DATA_W(DATA_W), .IDX_W(FIELD_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (alu_ok),
    .waddr (insn.dst),
    .wdata (alu_res),
    .ra    (insn.src_a),
    .rb    (insn.src_b),
    .rdbg  (dbg_sel),
    .qa    (opa),
    .qb    (opb),
    .qdbg  (dbg_val)
  );

  rcore_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (insn.opc),
    .a      (opa),
    .b      (opb),
    .res    (alu_res),
    .res_ok (alu_ok)
  );

  assign pc_o = pc;

  // R8: unused operation codes never reach write-back
  assert_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn.opc > 4'd4) |-> !alu_ok);
endmodule

// File: tb/tiny_rcore_test.sv
module tiny_rcore_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [6:0]  prog_addr;
  logic [15:0] prog_data;
  logic [3:0]  dbg_sel;
  logic [7:0]  dbg_val;
  logic [6:0]  pc_o;

  tiny_rcore uut (
    .clk (clk), .rst_n (rst_n), .prog_we (prog_we), .prog_addr (prog_addr),
    .prog_data (prog_data), .dbg_sel (dbg_sel), .dbg_val (dbg_val), .pc_o (pc_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         pc_exp;
    logic [3:0] rix;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t       sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] mdl_mem [128];
  logic        patched [128];
  logic [7:0]  mdl_reg [16];
  int          mpc;
  localparam int NCYC = 276;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare one item per executed instruction
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      #2;
      check(pc_o == 7'(it.pc_exp), "R2 pc", int'(pc_o), it.pc_exp);
      dbg_sel = it.rix;
      #1;
      check(dbg_val == it.val, it.tag, int'(dbg_val), int'(it.val));
    end
  end

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0; dbg_sel = '0;
    for (int i = 0; i < 128; i++) begin
      mdl_mem[i] = 16'h6E00;  // unused opcode, no write
      patched[i] = 1'b0;
    end
    mdl_mem[0]  = 16'h4100; // NOT r1 = ~r0
    mdl_mem[1]  = 16'h1201; // SUB r2 = r0 - r1
    mdl_mem[2]  = 16'h0322; // ADD r3
    mdl_mem[3]  = 16'h0432; // ADD r4
    mdl_mem[4]  = 16'h0512; // ADD r5 = FF + 01 wraps
    mdl_mem[5]  = 16'h1621; // SUB r6 = 01 - FF wraps
    mdl_mem[6]  = 16'h2714; // AND r7
    mdl_mem[7]  = 16'h3832; // OR r8
    mdl_mem[8]  = 16'h0944; // ADD r9
    mdl_mem[9]  = 16'h5A12; // opcode 5, no write
    mdl_mem[10] = 16'hFB11; // opcode 15, no write
    mdl_mem[11] = 16'h4C95; // NOT r12, B field nonzero
    mdl_mem[12] = 16'h2B91; // AND r11
    mdl_mem[19] = 16'h3F10; // OR r15 (old word at patch collision)
    for (int i = 0; i < 16; i++) mdl_reg[i] = 8'h00;
    mpc = 0;

    repeat (2) @(negedge clk);
    // R1 reset state
    check(pc_o == 7'd0, "R1 pc in reset", int'(pc_o), 0);
    for (int r = 0; r < 16; r++) begin
      dbg_sel = 4'(r);
      #1;
      check(dbg_val == 8'h00, "R1 reg in reset", int'(dbg_val), 0);
    end

    // load program while held in reset (R9)
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 7'(a); prog_data = mdl_mem[a];
    end
    @(negedge clk);
    prog_we = 1'b0;
    check(pc_o == 7'd0, "R1 pc held", int'(pc_o), 0);
    rst_n = 1'b1;

    for (int c = 1; c <= NCYC; c++) begin
      logic [15:0] w;
      logic [7:0]  a, b, res;
      logic        wr;
      string       tag;
      int          wa;
      logic [15:0] wd;
      wa = -1; wd = '0;
      if (c == 20) begin wa = 19; wd = 16'h0DC2; end  // R10 collision
      if (c == 30) begin wa = 40; wd = 16'h1E39; end  // R9 ahead
      prog_we = (wa >= 0);
      prog_addr = (wa >= 0) ? 7'(wa) : 7'd0;
      prog_data = wd;

      w = mdl_mem[mpc];
      a = mdl_reg[w[7:4]];
      b = mdl_reg[w[3:0]];
      wr = 1'b1; res = 8'h00;
      case (w[15:12])
        4'd0: begin res = a + b; tag = "R3 R4 add"; end
        4'd1: begin res = a - b; tag = "R5 sub"; end
        4'd2: begin res = a & b; tag = "R6 and"; end
        4'd3: begin res = a | b; tag = "R6 or"; end
        4'd4: begin res = ~a;    tag = "R7 not"; end
        default: begin wr = 1'b0; tag = "R8 no write"; end
      endcase
      if (patched[mpc]) tag = {tag, " R9 patched"};
      if (wa == mpc) tag = {tag, " R10 old word"};
      if (wr) mdl_reg[w[11:8]] = res;
      if (wa >= 0) begin mdl_mem[wa] = wd; patched[wa] = 1'b1; end
      mpc = (mpc + 1) % 128;
      sb_q.push_back('{pc_exp: mpc, rix: w[11:8], val: mdl_reg[w[11:8]], tag: tag});
      @(negedge clk);
    end
    prog_we = 1'b0;
    // R11: scan every register while fill words run (no writes)
    for (int r = 0; r < 16; r++) begin
      dbg_sel = 4'(r);
      #1;
      check(dbg_val == mdl_reg[r], "R11 debug scan", int'(dbg_val), int'(mdl_reg[r]));
      @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule